// File: doc/BRIEF.md
# Streaming Test-Pattern Source

This block produces test symbols on a valid/ready streaming output. It can emit four pseudo-random bit sequences with different register lengths, a fast toggling word or a slow square-wave word. Software drives it through a small register interface, one write or one combinational read at a time. From there it starts and stops generation, picks the pattern, and sets an optional preamble. The preamble is a programmable word repeated for a programmable number of beats before the pattern begins.

A one-shot error-inject command flips one bit of the output, so a downstream checker can show that it detects corruption. The symbol width is a parameter and may be 8 or 10 bits. The output honours back-pressure: a symbol stays on the bus, unchanged, until the sink accepts it. No sequence state advances without that acceptance.

Top module: `prbs_stream_gen`

## Requirements
- R1: After reset `out_valid` is 0, and every readable register returns 0: status, pattern code, preamble enable, beat count and preamble word.
- R2: Register map, by address.
  - Address 1 holds the pattern code: 0, 1, 2 and 3 are the 7-, 15-, 23- and 31-bit sequences, 4 is the fast word and 5 is the slow word.
  - Address 2 bit 0 is preamble enable, address 3 is the beat count, and address 4 is the preamble word.
  - Each of these reads back what was last written.
  - A pattern code write above 5 is ignored.
- R3: At address 0, write bit 0 starts the generator when idle, and `out_valid` is high from the next cycle. Read bit 0 of address 0 is 1 while the generator runs.
- R4: The sequences use x^7+x^6+1, x^15+x^14+1, x^23+x^18+1 and x^31+x^28+1.
  - The register is seeded with all ones.
  - Each new bit is the XOR of the two tapped bits and is shifted in at the low end.
  - One symbol carries SYM_W successive new bits, the first generated bit in bit 0.
- R5: The fast word alternates bits with bit 0 set (0x155 at 10 bits, 0x55 at 8 bits). The slow word has its upper half ones (0x3E0 at 10 bits, 0xF0 at 8 bits). Both repeat on every beat.
- R6: When preamble enable is 1 and the beat count N is above 0, a start sends the preamble word for N accepted beats and then the pattern from its seed. With N = 0 no preamble is sent.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds. The sequence advances only on an accepted beat.
- R8: Write bit 1 at address 0 stops the generator: `out_valid` falls only after the beat on offer is accepted.
- R9: Write bit 2 at address 0 arms an injection, shown in read bit 1 of address 0.
  - While the injection is armed, bit 0 of the offered symbol is inverted.
  - The injection clears when that symbol is accepted, so only that symbol carries the flip.
  - A second strobe while one is armed is ignored.
- R10: Every start reseeds the sequence to all ones and restarts the preamble phase.
- R11: Pattern code writes are ignored while the generator runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | CSR_AW | Register address for read and write |
| csr_wdata | input | CSR_DW | Register write data |
| csr_rdata | output | CSR_DW | Register read data for `csr_addr` |
| out_valid | output | 1 | Symbol on offer |
| out_ready | input | 1 | Sink accepts the symbol |
| out_data | output | SYM_W | Generated symbol |

## Verification
The bench builds two copies of the block side by side, one at SYM_W = 10 and one at SYM_W = 8, and drives both from the same register and ready signals. This puts both slow-word shapes, both fast-word values and the width-dependent packing of every sequence within reach in the same run. The preamble word is truncated in the narrow copy. The ready patterns in the vector table mix stalls of one and several cycles with bursts, so both sequence advance and data holding are checked at each width.

// File: rtl/prbs_stream_gen.sv
module prbs_stream_gen #(
  parameter int SYM_W  = 10,
  parameter int BEAT_W = 8,
  parameter int CSR_AW = 3,
  parameter int CSR_DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [CSR_DW-1:0] csr_wdata,
  output logic [CSR_DW-1:0] csr_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SYM_W-1:0]  out_data
);
  localparam int ST_W = 31;
  localparam logic [2:0] PAT_LAST = 3'd5;
  localparam logic [SYM_W-1:0] LF_WORD = {SYM_W{1'b1}} << (SYM_W / 2);

  logic              running, stop_req, inj_pend, pre_en;
  logic [2:0]        pat_sel;
  logic [BEAT_W-1:0] pre_beats, pre_left;
  logic [SYM_W-1:0]  pre_word, pat_word, hf_word;
  logic [ST_W-1:0]   lfsr, lfsr_nx;

  function automatic logic [ST_W+SYM_W-1:0] prbs_adv(input logic [ST_W-1:0] s, input logic [2:0] p);
    logic [SYM_W-1:0] w;
    logic fb;
    w = '0;
    for (int i = 0; i < SYM_W; i++) begin
      case (p)
        3'd0:    fb = s[6]  ^ s[5];
        3'd1:    fb = s[14] ^ s[13];
        3'd2:    fb = s[22] ^ s[17];
        default: fb = s[30] ^ s[27];
      endcase
      s = {s[ST_W-2:0], fb};
      w[i] = fb;
    end
    return {s, w};
  endfunction

  wire hs      = running & out_ready;
  wire in_pre  = pre_left != '0;
  wire wr_ctrl = csr_wr && csr_addr == CSR_AW'(0);
  wire do_start = wr_ctrl & csr_wdata[0] & ~running;
  wire do_stop  = wr_ctrl & csr_wdata[1] & running;
  wire do_inj   = wr_ctrl & csr_wdata[2] & ~inj_pend;

  always_comb begin
    for (int i = 0; i < SYM_W; i++) hf_word[i] = ~i[0];
  end

  always_comb begin
    {lfsr_nx, pat_word} = prbs_adv(lfsr, pat_sel);
    if (pat_sel == 3'd4) begin
      pat_word = hf_word;
      lfsr_nx  = lfsr;
    end else if (pat_sel == 3'd5) begin
      pat_word = LF_WORD;
      lfsr_nx  = lfsr;
    end
  end

  assign out_valid = running;
  assign out_data  = (in_pre ? pre_word : pat_word) ^ {{(SYM_W-1){1'b0}}, inj_pend};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      stop_req <= 1'b0;
      inj_pend <= 1'b0;
      pre_left <= '0;
      lfsr     <= '1;
    end else begin
      if (do_start) begin
        running  <= 1'b1;
        stop_req <= 1'b0;
        lfsr     <= '1;
        pre_left <= pre_en ? pre_beats : '0;
      end else begin
        if (hs && (stop_req || do_stop)) begin
          running  <= 1'b0;
          stop_req <= 1'b0;
        end else if (do_stop) begin
          stop_req <= 1'b1;
        end
        if (hs) begin
          if (in_pre) pre_left <= pre_left - 1'b1;
          else        lfsr     <= lfsr_nx;
        end
      end
      if (hs)          inj_pend <= do_inj;
      else if (do_inj) inj_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_sel   <= '0;
      pre_en    <= 1'b0;
      pre_beats <= '0;
      pre_word  <= '0;
    end else if (csr_wr) begin
      case (csr_addr)
        CSR_AW'(1): if (!running && csr_wdata[2:0] <= PAT_LAST && csr_wdata[CSR_DW-1:3] == '0)
                      pat_sel <= csr_wdata[2:0];
        CSR_AW'(2): pre_en    <= csr_wdata[0];
        CSR_AW'(3): pre_beats <= csr_wdata[BEAT_W-1:0];
        CSR_AW'(4): pre_word  <= csr_wdata[SYM_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_addr)
      CSR_AW'(0): csr_rdata[1:0]        = {inj_pend, running};
      CSR_AW'(1): csr_rdata[2:0]        = pat_sel;
      CSR_AW'(2): csr_rdata[0]          = pre_en;
      CSR_AW'(3): csr_rdata[BEAT_W-1:0] = pre_beats;
      CSR_AW'(4): csr_rdata[SYM_W-1:0]  = pre_word;
      default: ;
    endcase
  end
endmodule

// File: rtl/prbs_stream_gen_chk.sv
module prbs_stream_gen_chk #(
  parameter int SYM_W  = 10,
  parameter int CSR_AW = 3,
  parameter int CSR_DW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_wr,
  input logic [CSR_AW-1:0] csr_addr,
  input logic [CSR_DW-1:0] csr_wdata,
  input logic              out_valid,
  input logic              out_ready,
  input logic [SYM_W-1:0]  out_data,
  input logic [2:0]        pat_sel,
  input logic              inj_pend
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R2
  pat_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n) pat_sel <= 3'd5);

  // R3
  start_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr && csr_addr == CSR_AW'(0) && csr_wdata[0] && !out_valid |=> out_valid);

  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !csr_wr |=> $stable(out_data));

  // R9
  inject_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inj_pend && out_valid && out_ready |=> !inj_pend);

  // R11
  pat_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && csr_wr && csr_addr == CSR_AW'(1) |=> $stable(pat_sel));
endmodule

bind prbs_stream_gen prbs_stream_gen_chk #(.SYM_W(SYM_W), .CSR_AW(CSR_AW), .CSR_DW(CSR_DW)) u_chk (.*);

// File: tb/test_prbs_stream_gen.sv
module test_prbs_stream_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  localparam logic [10:0] VEC [NVEC] = '{
    {3'd0, 8'hFF}, {3'd1, 8'hB5}, {3'd2, 8'hFF}, {3'd3, 8'h6D},
    {3'd4, 8'hF0}, {3'd5, 8'h0F}, {3'd0, 8'h33}, {3'd3, 8'hFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr = 1'b0;
  logic [2:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] rd10, rd8;
  logic        v10, v8;
  logic        out_ready = 1'b0;
  logic [9:0]  d10;
  logic [7:0]  d8;
  logic [30:0] m10, m8;
  logic [31:0] rv;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prbs_stream_gen #(.SYM_W(10)) i_prbs_stream_gen (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_rdata(rd10), .out_valid(v10), .out_ready(out_ready), .out_data(d10));

  prbs_stream_gen #(.SYM_W(8)) i_prbs_stream_gen_w8 (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_rdata(rd8), .out_valid(v8), .out_ready(out_ready), .out_data(d8));

  function automatic logic [15:0] mword(logic [30:0] s, int pat, int w);
    logic [15:0] r = '0;
    int n, t;
    logic fb;
    if (pat == 4) begin
      for (int i = 0; i < w; i++) r[i] = (i % 2 == 0);
      return r;
    end
    if (pat == 5) begin
      for (int i = 0; i < w; i++) r[i] = (i >= w / 2);
      return r;
    end
    n = (pat == 0) ? 7 : (pat == 1) ? 15 : (pat == 2) ? 23 : 31;
    t = (pat == 0) ? 6 : (pat == 1) ? 14 : (pat == 2) ? 18 : 28;
    for (int i = 0; i < w; i++) begin
      fb = s[n-1] ^ s[t-1];
      s = {s[29:0], fb};
      r[i] = fb;
    end
    return r;
  endfunction

  function automatic logic [30:0] mnext(logic [30:0] s, int pat, int w);
    int n, t;
    logic fb;
    if (pat >= 4) return s;
    n = (pat == 0) ? 7 : (pat == 1) ? 15 : (pat == 2) ? 23 : 31;
    t = (pat == 0) ? 6 : (pat == 1) ? 14 : (pat == 2) ? 18 : 28;
    for (int i = 0; i < w; i++) begin
      fb = s[n-1] ^ s[t-1];
      s = {s[29:0], fb};
    end
    return s;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic csr_write(logic [2:0] a, logic [31:0] d);
    csr_addr = a; csr_wdata = d; csr_wr = 1'b1;
    @(negedge clk);
    csr_wr = 1'b0; csr_wdata = '0;
  endtask

  task automatic csr_read(logic [2:0] a, output logic [31:0] d);
    csr_addr = a;
    #1;
    d = rd10;
  endtask

  task automatic stop_gen();
    csr_write(3'd0, 32'h2);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic start_gen();
    csr_write(3'd0, 32'h1);
    m10 = '1; m8 = '1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", {31'b0, v10}, 0);
    chk("R1 valid w8", {31'b0, v8}, 0);
    for (int a = 0; a < 5; a++) begin
      csr_read(3'(a), rv);
      chk("R1 readback", rv, 0);
    end

    // R4 R5 R7 vector table
    for (int k = 0; k < NVEC; k++) begin
      int pat = int'(VEC[k][10:8]);
      csr_write(3'd1, 32'(pat));
      csr_read(3'd1, rv);
      chk("R2 pattern readback", rv, 32'(pat));
      start_gen();
      csr_read(3'd0, rv);
      chk("R3 running status", rv & 32'h1, 1);
      for (int c = 0; c < 8; c++) begin
        chk("R3 valid", {30'b0, v10, v8}, 3);
        chk(pat >= 4 ? "R5 word 10b" : "R4 word 10b", 32'(d10), 32'(mword(m10, pat, 10)));
        chk(pat >= 4 ? "R5 word 8b" : "R4 word 8b", 32'(d8), 32'(mword(m8, pat, 8)));
        out_ready = VEC[k][c];
        if (out_ready) begin
          m10 = mnext(m10, pat, 10);
          m8 = mnext(m8, pat, 8);
        end
        @(negedge clk);
      end
      out_ready = 1'b0;
      stop_gen();
      chk("R8 idle after stop", {31'b0, v10}, 0);
    end

    // R5 fixed constants
    csr_write(3'd1, 32'd5);
    start_gen();
    chk("R5 slow 10b", 32'(d10), 32'h3E0);
    chk("R5 slow 8b", 32'(d8), 32'hF0);
    stop_gen();
    csr_write(3'd1, 32'd4);
    start_gen();
    chk("R5 fast 10b", 32'(d10), 32'h155);
    chk("R5 fast 8b", 32'(d8), 32'h55);
    stop_gen();

    // R2 illegal code ignored, preamble readbacks
    csr_write(3'd1, 32'd6);
    csr_read(3'd1, rv);
    chk("R2 code 6 ignored", rv, 4);
    csr_write(3'd2, 32'd1);
    csr_write(3'd3, 32'd3);
    csr_write(3'd4, 32'h2A5);
    csr_read(3'd2, rv); chk("R2 enable readback", rv, 1);
    csr_read(3'd3, rv); chk("R2 beats readback", rv, 3);
    csr_read(3'd4, rv); chk("R2 word readback", rv, 32'h2A5);

    // R6 preamble then pattern
    start_gen();
    out_ready = 1'b1;
    for (int c = 0; c < 5; c++) begin
      chk("R6 preamble 10b", 32'(d10), c < 3 ? 32'h2A5 : 32'h155);
      chk("R6 preamble 8b", 32'(d8), c < 3 ? 32'hA5 : 32'h55);
      @(negedge clk);
    end
    out_ready = 1'b0;
    stop_gen();
    // R10 preamble restarts
    start_gen();
    chk("R10 preamble restart", 32'(d10), 32'h2A5);
    stop_gen();
    // R6 zero beats
    csr_write(3'd3, 32'd0);
    start_gen();
    chk("R6 zero beats", 32'(d10), 32'h155);
    stop_gen();
    csr_write(3'd2, 32'd0);

    // R10 reseed after run
    csr_write(3'd1, 32'd1);
    start_gen();
    out_ready = 1'b1;
    repeat (5) @(negedge clk);
    out_ready = 1'b0;
    stop_gen();
    start_gen();
    chk("R10 reseed 10b", 32'(d10), 32'(mword('1, 1, 10)));
    chk("R10 reseed 8b", 32'(d8), 32'(mword('1, 1, 8)));
    stop_gen();

    // R8 stop waits for handshake, R11 pattern lock
    csr_write(3'd1, 32'd0);
    start_gen();
    csr_write(3'd1, 32'd3);
    csr_read(3'd1, rv);
    chk("R11 code locked", rv, 0);
    chk("R11 data unchanged", 32'(d10), 32'(mword(m10, 0, 10)));
    csr_write(3'd0, 32'h2);
    chk("R8 valid held", {31'b0, v10}, 1);
    chk("R8 data held", 32'(d10), 32'(mword(m10, 0, 10)));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R8 valid dropped", {31'b0, v10}, 0);
    csr_read(3'd0, rv);
    chk("R8 status idle", rv, 0);

    // R9 injection
    start_gen();
    csr_write(3'd0, 32'h4);
    csr_read(3'd0, rv);
    chk("R9 pending status", rv, 3);
    chk("R9 bit0 flipped", 32'(d10), 32'(mword(m10, 0, 10) ^ 16'h1));
    csr_write(3'd0, 32'h4);
    chk("R9 second strobe ignored", 32'(d10), 32'(mword(m10, 0, 10) ^ 16'h1));
    out_ready = 1'b1;
    m10 = mnext(m10, 0, 10);
    @(negedge clk);
    out_ready = 1'b0;
    chk("R9 single beat only", 32'(d10), 32'(mword(m10, 0, 10)));
    csr_read(3'd0, rv);
    chk("R9 pending cleared", rv, 1);
    stop_gen();

    finish_run();
  end
endmodule